// File: doc/BRIEF.md
# Interface Vector Field Unit

This block gives a small controller datapath bit-field access to an 8-bit I/O byte that lives on one of two external banks. A capture pulls one byte from the selected bank into a single shared latch; the extracted field is then presented combinationally to the datapath. The field is described by a 3-bit position code and a 3-bit length code.

A write shifts a value into the field position, merges it into the shared latch under the field mask, and one cycle later pulses a write strobe with the bank's 9-bit port address and the shifted byte. The latch is shared by both banks. A field copied from one bank to the other is a capture from the source bank followed by a write to the destination bank. The merge therefore keeps the bits that came from the source byte.

Top module: `ivec_field_unit`

## Requirements
- R1: After reset the latch is 0x00 (field_o reads 0x00 for any position/length), port_wr_o is 0, and port_wr_addr_o and port_wr_data_o are 0.
- R2: port_rd_addr_o is {1'b0, left_addr_i} when bank_sel_i is 0 (left) and {1'b1, right_addr_i} when bank_sel_i is 1 (right). It is combinational.
- R3: With cap_en_i high and wr_en_i low at a clock edge, the latch takes port_rd_data_i. Only one shared latch exists, whichever bank is selected.
- R4: field_o equals the latch rotated right by (7 − lsb_pos_i) mod 8 and ANDed with (2^len_code_i − 1). The field's least significant bit is latch bit 7 − lsb_pos_i, and bits of field_o above the length are 0.
- R5: A len_code_i of 0 selects a full 8-bit field for both extraction and write.
- R6: With wr_en_i high at a clock edge, let S = (7 − lsb_pos_i) mod 8, V = wr_value_i << S and M = fieldmask << S, both truncated to 8 bits. The latch becomes (latch AND NOT M) OR (V AND M).
- R7: In the cycle after a write edge, port_wr_o is 1 for exactly one cycle. In that cycle port_wr_data_o is the whole byte V, including bits outside M. port_wr_addr_o is the address of the bank that was selected at the write edge, formed as in R2.
- R8: When cap_en_i and wr_en_i are both high at the same edge, the write wins and the captured byte is discarded.
- R9: A capture from one bank followed by a write to the other bank merges the written field into the source bank's byte. The unselected bits keep the source bank's values.
- R10: With neither cap_en_i nor wr_en_i high, the latch holds its value and port_wr_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_i | input | 1 | Bank select: 0 left, 1 right |
| left_addr_i | input | 8 | Left bank address register |
| right_addr_i | input | 8 | Right bank address register |
| lsb_pos_i | input | 3 | Field position code |
| len_code_i | input | 3 | Field length, 0 means 8 |
| cap_en_i | input | 1 | Capture the selected bank's byte |
| port_rd_data_i | input | 8 | Read data from the port |
| wr_en_i | input | 1 | Merge and write a field |
| wr_value_i | input | 8 | Value to place in the field |
| field_o | output | 8 | Extracted field, right-aligned |
| port_rd_addr_o | output | 9 | Read address of the selected bank |
| port_wr_addr_o | output | 9 | Registered write address |
| port_wr_data_o | output | 8 | Registered write byte |
| port_wr_o | output | 1 | One-cycle write strobe |

## Verification
The checker watches four things on every cycle. The strobe must be a one-cycle echo of each write request. The strobe address must carry the bank bit chosen at the write edge. No extracted field may have bits set above its length, and a plain capture must read back whole at the full-byte setting. The bench's directed scenarios cover the remaining behaviour. These are the rotate amounts at each position and the merge that keeps the unmasked bits. They also include the write-over-capture priority, the full byte sent to the port, and the bank-to-bank copy through the shared latch.

// File: rtl/ivec_field_unit.sv
module ivec_field_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_sel_i,
  input  logic [7:0] left_addr_i,
  input  logic [7:0] right_addr_i,
  input  logic [2:0] lsb_pos_i,
  input  logic [2:0] len_code_i,
  input  logic       cap_en_i,
  input  logic [7:0] port_rd_data_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_value_i,
  output logic [7:0] field_o,
  output logic [8:0] port_rd_addr_o,
  output logic [8:0] port_wr_addr_o,
  output logic [7:0] port_wr_data_o,
  output logic       port_wr_o
);

  logic [7:0] latch_q;
  logic [2:0] amt;
  logic [7:0] fmask;
  logic [7:0] rot1, rot2, rot3;
  logic [7:0] wval, wmask;
  logic [8:0] sel_addr;

  assign amt   = ~lsb_pos_i;
  assign fmask = (len_code_i == 3'd0) ? 8'hFF : ((8'd1 << len_code_i) - 8'd1);

  assign rot1 = amt[0] ? {latch_q[0],   latch_q[7:1]} : latch_q;
  assign rot2 = amt[1] ? {rot1[1:0],    rot1[7:2]}    : rot1;
  assign rot3 = amt[2] ? {rot2[3:0],    rot2[7:4]}    : rot2;

  assign field_o = rot3 & fmask;

  assign wval  = wr_value_i << amt;
  assign wmask = fmask << amt;

  assign sel_addr       = bank_sel_i ? {1'b1, right_addr_i} : {1'b0, left_addr_i};
  assign port_rd_addr_o = sel_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q        <= 8'h00;
      port_wr_o      <= 1'b0;
      port_wr_addr_o <= 9'h000;
      port_wr_data_o <= 8'h00;
    end else begin
      port_wr_o <= wr_en_i;
      if (wr_en_i) begin
        latch_q        <= (latch_q & ~wmask) | (wval & wmask);
        port_wr_addr_o <= sel_addr;
        port_wr_data_o <= wval;
      end else if (cap_en_i) begin
        latch_q <= port_rd_data_i;
      end
    end
  end

endmodule

// File: rtl/ivec_field_unit_chk.sv
module ivec_field_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_sel_i,
  input logic [2:0] lsb_pos_i,
  input logic [2:0] len_code_i,
  input logic       cap_en_i,
  input logic       wr_en_i,
  input logic [7:0] port_rd_data_i,
  input logic [7:0] field_o,
  input logic [8:0] port_wr_addr_o,
  input logic       port_wr_o
);

  a_r7_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> port_wr_o);

  a_r10_no_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !port_wr_o);

  a_r7_bank_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (port_wr_addr_o[8] == $past(bank_sel_i)));

  a_r4_field_width: assert property (@(posedge clk) disable iff (!rst_n)
    (len_code_i != 3'd0) |-> ((field_o >> len_code_i) == 8'h00));

  a_r3_capture_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && !wr_en_i) |=>
      ((lsb_pos_i != 3'd7) || (len_code_i != 3'd0) || (field_o == $past(port_rd_data_i))));

endmodule

bind ivec_field_unit ivec_field_unit_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bank_sel_i    (bank_sel_i),
  .lsb_pos_i     (lsb_pos_i),
  .len_code_i    (len_code_i),
  .cap_en_i      (cap_en_i),
  .wr_en_i       (wr_en_i),
  .port_rd_data_i(port_rd_data_i),
  .field_o       (field_o),
  .port_wr_addr_o(port_wr_addr_o),
  .port_wr_o     (port_wr_o)
);

// File: tb/ivec_field_unit_tb.sv
module ivec_field_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_sel_i = 1'b0;
  logic [7:0] left_addr_i = 8'h00;
  logic [7:0] right_addr_i = 8'h00;
  logic [2:0] lsb_pos_i = 3'd7;
  logic [2:0] len_code_i = 3'd0;
  logic       cap_en_i = 1'b0;
  logic [7:0] port_rd_data_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_value_i = 8'h00;
  logic [7:0] field_o;
  logic [8:0] port_rd_addr_o;
  logic [8:0] port_wr_addr_o;
  logic [7:0] port_wr_data_o;
  logic       port_wr_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] model;

  always #2 clk = ~clk;

  ivec_field_unit dut_i (.*);

  function automatic logic [7:0] rotr(logic [7:0] b, int n);
    logic [7:0] r = b;
    for (int i = 0; i < n; i++) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [7:0] lmask(logic [2:0] len);
    return (len == 3'd0) ? 8'hFF : 8'((1 << len) - 1);
  endfunction

  function automatic logic [7:0] expect_field(logic [7:0] b, logic [2:0] p, logic [2:0] len);
    return rotr(b, 7 - p) & lmask(len);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(logic bank, logic [7:0] data);
    @(negedge clk);
    bank_sel_i = bank; port_rd_data_i = data; cap_en_i = 1'b1;
    @(negedge clk);
    cap_en_i = 1'b0;
    model = data;
  endtask

  task automatic write_field(logic bank, logic [2:0] p, logic [2:0] len, logic [7:0] v, logic also_cap);
    logic [7:0] sv, sm;
    logic [8:0] ea;
    sv = 8'(v << (7 - p));
    sm = 8'(lmask(len) << (7 - p));
    ea = bank ? {1'b1, right_addr_i} : {1'b0, left_addr_i};
    @(negedge clk);
    bank_sel_i = bank; lsb_pos_i = p; len_code_i = len; wr_value_i = v;
    wr_en_i = 1'b1; cap_en_i = also_cap; port_rd_data_i = ~model;
    @(negedge clk);
    wr_en_i = 1'b0; cap_en_i = 1'b0;
    model = (model & ~sm) | (sv & sm);
    chk("R7 strobe", 16'(port_wr_o), 16'd1);
    chk("R7 address", 16'(port_wr_addr_o), 16'(ea));
    chk("R7 full byte", 16'(port_wr_data_o), 16'(sv));
    @(negedge clk);
    chk("R7 single cycle", 16'(port_wr_o), 16'd0);
  endtask

  task automatic read_full(string req);
    lsb_pos_i = 3'd7; len_code_i = 3'd0;
    #1 chk(req, 16'(field_o), 16'(model));
  endtask

  task automatic t_reset;
    chk("R1 latch", 16'(field_o), 16'h0);
    chk("R1 strobe", 16'(port_wr_o), 16'h0);
    chk("R1 wr addr", 16'(port_wr_addr_o), 16'h0);
    chk("R1 wr data", 16'(port_wr_data_o), 16'h0);
  endtask

  task automatic t_addr;
    left_addr_i = 8'h3C; right_addr_i = 8'hA5;
    bank_sel_i = 1'b0; #1 chk("R2 left", 16'(port_rd_addr_o), 16'h03C);
    bank_sel_i = 1'b1; #1 chk("R2 right", 16'(port_rd_addr_o), 16'h1A5);
  endtask

  task automatic t_extract;
    capture(1'b0, 8'hB4);
    read_full("R3 capture left");
    for (int p = 0; p < 8; p++) begin
      for (int l = 1; l < 8; l += 3) begin
        lsb_pos_i = 3'(p); len_code_i = 3'(l);
        #1 chk("R4 extract", 16'(field_o), 16'(expect_field(model, 3'(p), 3'(l))));
      end
    end
    capture(1'b1, 8'h5E);
    read_full("R3 capture right shares latch");
  endtask

  task automatic t_len_zero;
    capture(1'b0, 8'hC3);
    lsb_pos_i = 3'd4; len_code_i = 3'd0;
    #1 chk("R5 eight-bit extract", 16'(field_o), 16'(rotr(8'hC3, 3)));
    write_field(1'b0, 3'd2, 3'd0, 8'h96, 1'b0);
    read_full("R5 eight-bit write");
  endtask

  task automatic t_merge;
    capture(1'b0, 8'hB4);
    write_field(1'b0, 3'd4, 3'd2, 8'hFD, 1'b0);
    read_full("R6 merge keeps outside bits");
    write_field(1'b1, 3'd0, 3'd3, 8'h02, 1'b0);
    read_full("R6 merge wrap position");
  endtask

  task automatic t_priority;
    capture(1'b0, 8'h0F);
    write_field(1'b0, 3'd7, 3'd4, 8'h0A, 1'b1);
    read_full("R8 write beats capture");
  endtask

  task automatic t_bank_copy;
    capture(1'b0, 8'h71);
    write_field(1'b1, 3'd5, 3'd3, 8'h06, 1'b0);
    read_full("R9 source bits kept in destination");
    chk("R9 expected byte", 16'(model), 16'h79);
  endtask

  task automatic t_hold;
    capture(1'b1, 8'hE2);
    port_rd_data_i = 8'h1D;
    repeat (3) begin
      @(negedge clk);
      chk("R10 no strobe", 16'(port_wr_o), 16'd0);
    end
    read_full("R10 latch holds");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_addr;
    t_extract;
    t_len_zero;
    t_merge;
    t_priority;
    t_bank_copy;
    t_hold;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule